// File: doc/BRIEF.md
# Prescaled 24-bit Time Base Counter

This block keeps a free-running 24-bit count that other logic on the chip uses as a common time reference. The count advances by one on every tick of a prescaler. The prescaler runs either from the system clock, where it divides by an even ratio between 2 and 512, or from an external clock pin, where it counts rising edges and divides by any ratio from 1 to 256. The external pin is brought into the clock domain by a two-flop synchroniser, and only its rising edges are counted.

The processing engine can load the count at any time through a write port, and it reads the count through its own read port. The host has a read-only view. Write attempts on the host side never reach the count. Whenever the source select or the ratio field changes, the prescaler clears its divider and starts over, and the count keeps its value. An advance pulse is high for one cycle together with each new count value, so downstream logic can sample the value on that cycle.

The prescaler is a three-state machine. RESTART is entered on reset and on any configuration change. It holds the divider at zero for one cycle. It then moves to SYS_DIV when the source select is 0, or to EXT_DIV when it is 1. SYS_DIV and EXT_DIV each stay in place until the configuration changes again, and a change sends either one back to RESTART.

Top module: `tbase_counter`

## Requirements
- R1: After reset the count is 0 on both read ports and the advance pulse is low.
- R2: With source select 0 (system clock), the count advances once every 2 × (ratio field + 1) clock cycles. Field 0 gives 2 and field 255 gives 512.
- R3: With source select 1 (external pin), the count advances once per (ratio field + 1) rising edges of the synchronised pin. A falling edge never advances the count.
- R4: The pin passes through two synchroniser flops. A rising edge driven just before clock edge E0 advances the count at edge E0+2.
- R5: The count wraps modulo 2^24, so 0xFFFFFF advances to 0x000000.
- R6: An engine write loads the count at the next clock edge and wins over an advance in the same cycle. That cycle produces no advance pulse, and the divider still restarts its period.
- R7: A host write strobe, whatever its data, has no effect on the count.
- R8: The engine and host read ports always show the same count.
- R9: A change of source select or ratio field sends the prescaler through RESTART and clears the divider, and the count keeps its value. In system-clock mode with the new ratio giving period N, the first advance after a change seen at edge E0 lands at edge E0+N+1.
- R10: The advance pulse is high for exactly one cycle with each new count value, and each advance adds exactly 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk_pin | input | 1 | External clock pin, asynchronous |
| src_sel | input | 1 | Clock source: 0 = system clock, 1 = external pin |
| ratio_fld | input | 8 | Prescaler ratio field (see R2, R3) |
| eng_wr_en | input | 1 | Engine write strobe |
| eng_wr_data | input | 24 | Engine write value |
| eng_rd_data | output | 24 | Engine read port |
| host_wr_en | input | 1 | Host write strobe (ignored) |
| host_wr_data | input | 24 | Host write value (ignored) |
| host_rd_data | output | 24 | Host read-only port |
| adv_pulse | output | 1 | One-cycle pulse with each count advance |

## Verification
The vector table sweeps the ratio field at its smallest, largest and two middle values in both source modes, and measures the gap in cycles between consecutive advance pulses. An off-by-one in the even scaling shows up as a different gap from one in the integer scaling. In external mode the pin toggle rate is varied, so a design that counts both pin edges, or that counts system clocks instead of pin edges, produces the wrong gap. The directed tests pin down the synchroniser latency and the restart delay after a ratio change. They also cover an engine write that lands on an advance cycle and the wrap at the top of the count, and they confirm that a host write and a falling pin edge leave the count unchanged.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

    typedef enum logic [1:0] {
        PS_RESTART = 2'd0,
        PS_SYS_DIV = 2'd1,
        PS_EXT_DIV = 2'd2
    } ps_state_e;

    localparam logic SRC_SYSCLK = 1'b0;
    localparam logic SRC_EXTPIN = 1'b1;

endpackage

// File: rtl/tbase_pin_sync.sv
module tbase_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic pin_rise
);
    // chain[STAGES-1] is the synchronised level, chain[STAGES] its previous value
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-1:0], pin_async};
        end
    end

    assign pin_rise = chain_q[STAGES-1] & ~chain_q[STAGES];

    // R4
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pin_rise |=> !pin_rise);

endmodule

// File: rtl/tbase_prescaler.sv
module tbase_prescaler
    import tbase_pkg::*;
#(
    parameter int RATIO_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               src_sel,
    input  logic [RATIO_W-1:0] ratio_fld,
    input  logic               ext_rise,
    output logic               adv
);
    localparam int DIV_W = RATIO_W + 1;

    ps_state_e          st_q, st_d;
    logic               src_q;
    logic [RATIO_W-1:0] ratio_q;
    logic [DIV_W-1:0]   div_q, div_d;
    logic [DIV_W-1:0]   sys_term, ext_term;
    logic               cfg_chg;

    assign cfg_chg  = (src_sel != src_q) || (ratio_fld != ratio_q);
    assign sys_term = {ratio_q, 1'b1};
    assign ext_term = {1'b0, ratio_q};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= PS_RESTART;
            src_q   <= SRC_SYSCLK;
            ratio_q <= '0;
            div_q   <= '0;
        end else begin
            st_q    <= st_d;
            src_q   <= src_sel;
            ratio_q <= ratio_fld;
            div_q   <= div_d;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        if (cfg_chg) begin
            st_d = PS_RESTART;
        end else begin
            unique case (st_q)
                PS_RESTART: st_d = (src_q == SRC_EXTPIN) ? PS_EXT_DIV : PS_SYS_DIV;
                PS_SYS_DIV: st_d = PS_SYS_DIV;
                PS_EXT_DIV: st_d = PS_EXT_DIV;
                default:    st_d = PS_RESTART;
            endcase
        end
    end

    // outputs and divider
    always_comb begin
        adv   = 1'b0;
        div_d = div_q;
        if (cfg_chg) begin
            div_d = '0;
        end else begin
            unique case (st_q)
                PS_RESTART: div_d = '0;
                PS_SYS_DIV: begin
                    if (div_q == sys_term) begin
                        adv   = 1'b1;
                        div_d = '0;
                    end else begin
                        div_d = div_q + 1'b1;
                    end
                end
                PS_EXT_DIV: begin
                    if (ext_rise) begin
                        if (div_q == ext_term) begin
                            adv   = 1'b1;
                            div_d = '0;
                        end else begin
                            div_d = div_q + 1'b1;
                        end
                    end
                end
                default: div_d = '0;
            endcase
        end
    end

    // R9
    restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_chg) |-> (st_q == PS_RESTART && div_q == '0));

    // R2
    sys_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PS_SYS_DIV) |-> (div_q <= sys_term));

    // R3
    ext_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && st_q == PS_EXT_DIV) |-> ext_rise);

endmodule

// File: rtl/tbase_count_reg.sv
module tbase_count_reg #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] count,
    output logic             adv_pulse
);
    logic [CNT_W-1:0] count_q;
    logic             pulse_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= adv & ~wr_en;
            if (wr_en) begin
                count_q <= wr_data;
            end else if (adv) begin
                count_q <= count_q + 1'b1;
            end
        end
    end

    assign count     = count_q;
    assign adv_pulse = pulse_q;

    // R10
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |-> (count_q == CNT_W'($past(count_q) + 1'b1)));

    // R6
    write_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en) |-> (count_q == $past(wr_data) && !pulse_q));

endmodule

// File: rtl/tbase_counter.sv
module tbase_counter #(
    parameter int CNT_W       = 24,
    parameter int RATIO_W     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ext_clk_pin,
    input  logic               src_sel,
    input  logic [RATIO_W-1:0] ratio_fld,
    input  logic               eng_wr_en,
    input  logic [CNT_W-1:0]   eng_wr_data,
    output logic [CNT_W-1:0]   eng_rd_data,
    input  logic               host_wr_en,
    input  logic [CNT_W-1:0]   host_wr_data,
    output logic [CNT_W-1:0]   host_rd_data,
    output logic               adv_pulse
);
    logic             ext_rise;
    logic             adv;
    logic [CNT_W-1:0] count;

    tbase_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (ext_clk_pin),
        .pin_rise  (ext_rise)
    );

    tbase_prescaler #(.RATIO_W(RATIO_W)) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_sel   (src_sel),
        .ratio_fld (ratio_fld),
        .ext_rise  (ext_rise),
        .adv       (adv)
    );

    tbase_count_reg #(.CNT_W(CNT_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (adv),
        .wr_en     (eng_wr_en),
        .wr_data   (eng_wr_data),
        .count     (count),
        .adv_pulse (adv_pulse)
    );

    assign eng_rd_data  = count;
    assign host_rd_data = count;

    // R7
    host_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_en && host_wr_data != count && !eng_wr_en && !adv)
            |=> (host_rd_data == $past(count)));

endmodule

// File: tb/tbase_counter_test.sv
module tbase_counter_test;

    typedef struct packed {
        logic       src;
        logic [7:0] ratio;
        int         half;
        int         period;
    } vec_t;

    // src, ratio field, pin half-period (cycles), expected advance gap (cycles)
    localparam vec_t VECS [8] = '{
        '{1'b0, 8'd0,   0, 2},
        '{1'b0, 8'd3,   0, 8},
        '{1'b0, 8'd10,  0, 22},
        '{1'b0, 8'd255, 0, 512},
        '{1'b1, 8'd0,   3, 6},
        '{1'b1, 8'd2,   3, 18},
        '{1'b1, 8'd4,   2, 20},
        '{1'b1, 8'd255, 1, 512}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_clk_pin = 1'b0;
    logic        src_sel = 1'b0;
    logic [7:0]  ratio_fld = 8'd0;
    logic        eng_wr_en = 1'b0;
    logic [23:0] eng_wr_data = '0;
    logic        host_wr_en = 1'b0;
    logic [23:0] host_wr_data = '0;
    logic [23:0] eng_rd_data, host_rd_data;
    logic        adv_pulse;

    int errors = 0;
    int checks = 0;
    int ext_half = 0;

    tbase_counter uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ext_clk_pin  (ext_clk_pin),
        .src_sel      (src_sel),
        .ratio_fld    (ratio_fld),
        .eng_wr_en    (eng_wr_en),
        .eng_wr_data  (eng_wr_data),
        .eng_rd_data  (eng_rd_data),
        .host_wr_en   (host_wr_en),
        .host_wr_data (host_wr_data),
        .host_rd_data (host_rd_data),
        .adv_pulse    (adv_pulse)
    );

    always #4 clk = ~clk;

    initial begin
        forever begin
            if (ext_half == 0) begin
                @(negedge clk);
            end else begin
                repeat (ext_half) @(negedge clk);
                ext_clk_pin = ~ext_clk_pin;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wait_adv(output int n);
        n = 0;
        do begin
            step();
            n++;
        end while (!adv_pulse && n < 3000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n;
        logic [23:0] c;
        logic held;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 count", {8'd0, eng_rd_data}, 32'd0);
        check("R1 pulse", {31'd0, adv_pulse}, 32'd0);
        rst_n = 1'b1;
        check("R8 ports", {8'd0, host_rd_data}, {8'd0, eng_rd_data});

        // vector table: R2 and R3 gaps, R10 step
        for (int i = 0; i < 8; i++) begin
            src_sel   = VECS[i].src;
            ratio_fld = VECS[i].ratio;
            ext_half  = VECS[i].half;
            wait_adv(n);
            c = eng_rd_data;
            wait_adv(n);
            check(VECS[i].src ? "R3 gap" : "R2 gap", n, VECS[i].period);
            check("R10 step", {8'd0, eng_rd_data}, {8'd0, c + 24'd1});
            step();
            check("R10 single", {31'd0, adv_pulse}, 32'd0);
            check("R8 ports", {8'd0, host_rd_data}, {8'd0, eng_rd_data});
        end

        // R6 write coincident with an advance (system clock, field 0)
        ext_half = 0;
        src_sel = 1'b0;
        ratio_fld = 8'd0;
        wait_adv(n);
        wait_adv(n);
        step();
        eng_wr_en = 1'b1;
        eng_wr_data = 24'hABCDEF;
        step();
        eng_wr_en = 1'b0;
        check("R6 load", {8'd0, eng_rd_data}, 32'h00ABCDEF);
        check("R6 no pulse", {31'd0, adv_pulse}, 32'd0);
        wait_adv(n);
        check("R6 next", {8'd0, eng_rd_data}, 32'h00ABCDF0);

        // R5 wrap
        eng_wr_en = 1'b1;
        eng_wr_data = 24'hFFFFFF;
        step();
        eng_wr_en = 1'b0;
        wait_adv(n);
        check("R5 wrap", {8'd0, eng_rd_data}, 32'd0);

        // R9 ratio change restarts divider, count kept
        ratio_fld = 8'd3;
        wait_adv(n);
        wait_adv(n);
        repeat (3) step();
        c = eng_rd_data;
        ratio_fld = 8'd1;
        n = 0;
        held = 1'b1;
        do begin
            step();
            n++;
            if (!adv_pulse && eng_rd_data != c) held = 1'b0;
        end while (!adv_pulse && n < 100);
        check("R9 restart gap", n, 32'd6);
        check("R9 count kept", {31'd0, held}, 32'd1);
        check("R9 next", {8'd0, eng_rd_data}, {8'd0, c + 24'd1});

        // R4 synchroniser latency, then R3 falling edge ignored
        src_sel = 1'b1;
        ratio_fld = 8'd0;
        ext_clk_pin = 1'b0;
        repeat (6) step();
        c = eng_rd_data;
        ext_clk_pin = 1'b1;
        wait_adv(n);
        check("R4 latency", n, 32'd3);
        check("R4 count", {8'd0, eng_rd_data}, {8'd0, c + 24'd1});
        c = eng_rd_data;
        ext_clk_pin = 1'b0;
        repeat (6) step();
        check("R3 fall ignored", {8'd0, eng_rd_data}, {8'd0, c});

        // R7 host write ignored
        host_wr_en = 1'b1;
        host_wr_data = 24'h123456;
        repeat (4) step();
        host_wr_en = 1'b0;
        step();
        check("R7 host write", {8'd0, eng_rd_data}, {8'd0, c});
        check("R8 ports", {8'd0, host_rd_data}, {8'd0, c});

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule